// File: doc/BRIEF.md
# Bidirectional Timer With Output Compare

An 8-bit up/down timer whose count advances only on a selectable tick. A 3-bit select input chooses the tick: none, every system clock, the system clock divided by 8, 64, 256 or 1024 (taken from one shared free-running divider), or one edge of an external pin after a two-flop synchronizer. On each tick the counter clears, increments or decrements, and it reports when it sits at its maximum or at zero. A host bus can write the count at any time, and the count is always visible at an output.

Two compare channels each hold a host-written buffer value. The buffer moves into the channel's active compare value only while the count is zero, so a new threshold takes effect cleanly at the bottom of a cycle. The active value is compared with the count on every clock. A channel raises its sticky flag when the count newly becomes equal to the active value. A separate sticky overflow flag records an upward wrap from 0xFF to 0x00. All flags are cleared by writing 1, and they serve directly as interrupt requests.

Top module: `updown_cmp_timer`

## Requirements
- R1: With select 0 no tick occurs and the count holds, while a host write to the count still takes effect on the next clock.
- R2: With select 1 the count changes on every clock edge.
- R3: Selects 2, 3, 4 and 5 tick once every 8, 64, 256 and 1024 clocks. Any window of k times that many clocks holds exactly k ticks.
- R4: Select 7 ticks once per rising edge of the external pin and select 6 once per falling edge. The other edge is ignored. When the pin changes between clock edges, the count changes on the third clock edge that follows.
- R5: On a tick with count_down_i=0 the count increments, wrapping 0xFF to 0x00. With count_down_i=1 it decrements, wrapping 0x00 to 0xFF.
- R6: On a tick with count_clr_i=1 the count becomes 0x00, whatever the direction.
- R7: cnt_wr_i=1 loads wr_data_i into the count on the next edge, overriding any tick, clear or direction in that cycle.
- R8: top_o is 1 exactly when the count is 0xFF, and bottom_o is 1 exactly when it is 0x00.
- R9: cmp_wr_i[n] writes wr_data_i into the buffer of channel n. A buffer value becomes the active compare value only on an edge where the count is 0x00.
- R10: cmp_flag_o[n] sets one clock after the count newly equals channel n's active value, whether through a tick or a write. It stays set.
- R11: ovf_flag_o sets on an upward tick from 0xFF to 0x00 and stays set. A downward wrap does not set it.
- R12: A 1 on ovf_clr_i or cmp_clr_i[n] clears that flag on the next edge. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Tick select: 0 off, 1 clock, 2..5 divide by 8/64/256/1024, 6 pin falling edge, 7 pin rising edge |
| ext_clk_i | input | 1 | External tick pin, asynchronous |
| count_down_i | input | 1 | 1 to decrement on a tick, 0 to increment |
| count_clr_i | input | 1 | Clear the count on a tick |
| cnt_wr_i | input | 1 | Host write strobe for the count |
| cmp_wr_i | input | 2 | Host write strobes for the compare buffers, one per channel |
| wr_data_i | input | 8 | Host write data |
| ovf_clr_i | input | 1 | Write-1 clear of the overflow flag |
| cmp_clr_i | input | 2 | Write-1 clears of the compare flags |
| cnt_o | output | 8 | Current count |
| top_o | output | 1 | Count is 0xFF |
| bottom_o | output | 1 | Count is 0x00 |
| ovf_flag_o | output | 1 | Sticky overflow flag, interrupt request |
| cmp_flag_o | output | 2 | Sticky compare flags, interrupt requests |

## Verification
A wrong divider tap or synchronizer depth shows first as a count that is off by whole ticks at the end of a divide window, or that moves one clock early or late after a pin edge. A wrong active compare value stays hidden until the count reaches the stale threshold. It then shows as a flag that rises one clock after the count passes a value it should have ignored, or that fails to rise at the intended one. The bench places each compare and overflow check on the exact clock after the triggering count, and it pairs a flag clear with a possible set event. Either error therefore shows within one clock of the count value that exposes it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_CLK      = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam int unsigned NUM_DIV = 4;

  // log2 of each divide ratio, in select order
  function automatic int unsigned div_shift(int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int unsigned PRE_W = div_shift(NUM_DIV - 1);
endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_i,
  output logic       tick_o
);
  logic [PRE_W-1:0]   pre_q;
  logic [2:0]         sync_q;  // [1:0] synchronizer, [2] previous sample
  logic [NUM_DIV-1:0] div_hit;
  logic               ext_rise, ext_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_i};
    end
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam int unsigned SH = div_shift(g);
    assign div_hit[g] = &pre_q[SH-1:0];
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    case (clk_sel_e'(sel_i))
      SEL_CLK:      tick_o = 1'b1;
      SEL_DIV8:     tick_o = div_hit[0];
      SEL_DIV64:    tick_o = div_hit[1];
      SEL_DIV256:   tick_o = div_hit[2];
      SEL_DIV1024:  tick_o = div_hit[3];
      SEL_EXT_FALL: tick_o = ext_fall;
      SEL_EXT_RISE: tick_o = ext_rise;
      default:      tick_o = 1'b0;
    endcase
  end

  p_off_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_OFF) |-> !tick_o);
  p_ext_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_EXT_RISE && tick_o) |=> !(sel_i == SEL_EXT_RISE && tick_o));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         down_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         top_o,
  output logic         bottom_o,
  output logic         ovf_evt_o
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d     = cnt_q;
    ovf_evt_o = 1'b0;
    if (wr_i) begin
      cnt_d = wr_data_i;
    end else if (tick_i) begin
      if (clr_i)       cnt_d = '0;
      else if (down_i) cnt_d = cnt_q - ONE;
      else begin
        cnt_d     = cnt_q + ONE;
        ovf_evt_o = (cnt_q == MAX);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign top_o    = (cnt_q == MAX);
  assign bottom_o = (cnt_q == '0);

  p_write_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wr_data_i));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && clr_i && !wr_i) |=> cnt_q == '0);
  p_ovf_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> (cnt_q == '0) && $past(top_o));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buf_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [W-1:0] buf_q, act_q;
  logic         match, match_q, set, flag_q;

  assign match = (cnt_i == act_q);
  assign set   = match & ~match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      act_q   <= '0;
      match_q <= 1'b1;  // no flag for the reset-time match
      flag_q  <= 1'b0;
    end else begin
      if (buf_wr_i) buf_q <= wr_data_i;
      if (load_i)   act_q <= buf_q;
      match_q <= match;
      flag_q  <= set | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;

  p_flag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !match_q) |=> flag_q);
  p_flag_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(match && !match_q)) |=> !flag_q);
  p_reload_bottom_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/updown_cmp_timer.sv
module updown_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        clk_sel_i,
  input  logic              ext_clk_i,
  input  logic              count_down_i,
  input  logic              count_clr_i,
  input  logic              cnt_wr_i,
  input  logic [NUM_CH-1:0] cmp_wr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              ovf_clr_i,
  input  logic [NUM_CH-1:0] cmp_clr_i,
  output logic [W-1:0]      cnt_o,
  output logic              top_o,
  output logic              bottom_o,
  output logic              ovf_flag_o,
  output logic [NUM_CH-1:0] cmp_flag_o
);
  logic         tick, ovf_evt, ovf_q, at_bottom;
  logic [W-1:0] cnt;

  tmr_clk_sel u_clk_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel_i),
    .ext_i  (ext_clk_i),
    .tick_o (tick)
  );

  tmr_counter #(.W(W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .clr_i     (count_clr_i),
    .down_i    (count_down_i),
    .wr_i      (cnt_wr_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt),
    .top_o     (top_o),
    .bottom_o  (at_bottom),
    .ovf_evt_o (ovf_evt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_cmp_chan #(.W(W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .buf_wr_i  (cmp_wr_i[c]),
      .wr_data_i (wr_data_i),
      .load_i    (at_bottom),
      .cnt_i     (cnt),
      .clr_i     (cmp_clr_i[c]),
      .flag_o    (cmp_flag_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_evt | (ovf_q & ~ovf_clr_i);
  end

  assign cnt_o      = cnt;
  assign bottom_o   = at_bottom;
  assign ovf_flag_o = ovf_q;

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  p_ovf_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !ovf_evt) |=> !ovf_q);
endmodule

// File: tb/updown_cmp_timer_bench.sv
`timescale 1ns/1ps
module updown_cmp_timer_bench;
  localparam int K_CNT = 0, K_TOP = 1, K_BOT = 2, K_OVF = 3, K_CMP = 4;

  typedef struct {
    int    kind;
    int    exp;
    string req;
  } item_t;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] clk_sel = '0;
  logic       ext_clk = 1'b0, down = 1'b0, cclr = 1'b0, cnt_wr = 1'b0, ovf_clr = 1'b0;
  logic [1:0] cmp_wr = '0, cmp_clr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] cnt;
  logic       top, bot, ovf;
  logic [1:0] cmpf;

  item_t sb_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  updown_cmp_timer u_updown_cmp_timer (
    .clk_i(clk), .rst_ni(rst_ni), .clk_sel_i(clk_sel), .ext_clk_i(ext_clk),
    .count_down_i(down), .count_clr_i(cclr), .cnt_wr_i(cnt_wr), .cmp_wr_i(cmp_wr),
    .wr_data_i(wdata), .ovf_clr_i(ovf_clr), .cmp_clr_i(cmp_clr), .cnt_o(cnt),
    .top_o(top), .bottom_o(bot), .ovf_flag_o(ovf), .cmp_flag_o(cmpf)
  );

  function automatic int actual(int kind);
    case (kind)
      K_CNT:   return int'(cnt);
      K_TOP:   return int'(top);
      K_BOT:   return int'(bot);
      K_OVF:   return int'(ovf);
      default: return int'(cmpf);
    endcase
  endfunction

  // driver side: queue what the outputs must show at this negedge
  task automatic expect_item(int kind, int exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic nx(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it  = sb_q.pop_front();
      act = actual(it.kind);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    nx(3);
    rst_ni = 1'b1;
    expect_item(K_CNT, 0, "R1 reset count");
    expect_item(K_BOT, 1, "R8 reset bottom");
    expect_item(K_TOP, 0, "R8 reset top");
    expect_item(K_OVF, 0, "R11 reset ovf");
    expect_item(K_CMP, 0, "R10 reset cmp flags");
    nx(5);
    expect_item(K_CNT, 0, "R1 stopped hold");

    cnt_wr = 1; wdata = 8'h10;
    nx(); cnt_wr = 0;
    expect_item(K_CNT, 8'h10, "R1 write while stopped");
    expect_item(K_BOT, 0, "R8 bottom off");

    clk_sel = 3'd1;
    nx(5); expect_item(K_CNT, 8'h15, "R2 tick every clock");
    down = 1;
    nx(3); expect_item(K_CNT, 8'h12, "R5 decrement");

    cnt_wr = 1; wdata = 8'hFE; down = 0;
    nx(); cnt_wr = 0;
    expect_item(K_CNT, 8'hFE, "R7 write beats tick");
    nx(); expect_item(K_CNT, 8'hFF, "R5 up to max");
    expect_item(K_TOP, 1, "R8 top at max");
    nx(); expect_item(K_CNT, 8'h00, "R5 up wrap");
    expect_item(K_BOT, 1, "R8 bottom at zero");
    expect_item(K_TOP, 0, "R8 top off");
    expect_item(K_OVF, 1, "R11 ovf on up wrap");
    clk_sel = 3'd0;
    nx(); expect_item(K_CMP, 3, "R10 both flags at match with zero");
    expect_item(K_CNT, 0, "R1 held after stop");
    ovf_clr = 1; cmp_clr = 2'b11;
    nx(); ovf_clr = 0; cmp_clr = 0;
    expect_item(K_OVF, 0, "R12 ovf cleared");
    expect_item(K_CMP, 0, "R12 cmp cleared");

    cnt_wr = 1; wdata = 8'h01;
    nx(); cnt_wr = 0;
    expect_item(K_CNT, 1, "R7 write");
    clk_sel = 3'd1; down = 1;
    nx(); expect_item(K_CNT, 0, "R5 down to zero");
    nx(); expect_item(K_CNT, 8'hFF, "R5 down wrap");
    expect_item(K_OVF, 0, "R11 no ovf on down wrap");

    cclr = 1;
    nx(); expect_item(K_CNT, 0, "R6 clear beats direction");
    nx(); expect_item(K_CNT, 0, "R6 clear holds zero");
    clk_sel = 3'd0; cclr = 0; down = 0;
    cmp_clr = 2'b11;
    nx(); cmp_clr = 0;
    expect_item(K_CMP, 0, "R12 cmp cleared at zero");

    cmp_wr = 2'b01; wdata = 8'h05;
    nx(); cmp_wr = 2'b10; wdata = 8'h08;
    nx(); cmp_wr = 0;
    nx();
    cnt_wr = 1; wdata = 8'h03;
    nx(); cnt_wr = 0;
    expect_item(K_CNT, 3, "R7 write");
    clk_sel = 3'd1;
    nx();
    nx(); expect_item(K_CNT, 5, "R2 count");
    expect_item(K_CMP, 0, "R10 flag not before one clock");
    cmp_wr = 2'b01; wdata = 8'h07;
    nx(); cmp_wr = 0;
    expect_item(K_CMP, 1, "R10 flag A at 5");
    nx(); cmp_clr = 2'b01;
    nx(); cmp_clr = 0;
    expect_item(K_CMP, 0, "R9 buffer not applied away from zero");
    expect_item(K_CNT, 8, "R2 count");
    nx(); expect_item(K_CMP, 2, "R10 flag B at 8");
    clk_sel = 3'd0;

    cnt_wr = 1; wdata = 8'h00;
    nx(); cnt_wr = 0;
    expect_item(K_CNT, 0, "R7 write zero");
    nx();
    cnt_wr = 1; wdata = 8'h07;
    nx(); cnt_wr = 0;
    expect_item(K_CNT, 7, "R7 write");
    cmp_clr = 2'b01;
    nx(); cmp_clr = 0;
    expect_item(K_CMP, 3, "R9 reload at zero, R12 set beats clear");
    cmp_clr = 2'b01;
    nx(); cmp_clr = 0;
    expect_item(K_CMP, 2, "R12 clear with no set");

    cnt_wr = 1; wdata = 8'h00;
    nx(); cnt_wr = 0; clk_sel = 3'd2;
    nx(80); expect_item(K_CNT, 10, "R3 divide by 8");
    clk_sel = 3'd0; cnt_wr = 1; wdata = 8'h00;
    nx(); cnt_wr = 0; clk_sel = 3'd3;
    nx(256); expect_item(K_CNT, 4, "R3 divide by 64");
    clk_sel = 3'd4;
    nx(512); expect_item(K_CNT, 6, "R3 divide by 256");
    clk_sel = 3'd5;
    nx(2048); expect_item(K_CNT, 8, "R3 divide by 1024");
    clk_sel = 3'd7;
    nx(3);
    ext_clk = 1;
    nx(2); expect_item(K_CNT, 8, "R4 rise not yet");
    nx(); expect_item(K_CNT, 9, "R4 rise tick on third edge");
    nx(4); expect_item(K_CNT, 9, "R4 one tick per edge");
    ext_clk = 0;
    nx(5); expect_item(K_CNT, 9, "R4 falling ignored in select 7");
    clk_sel = 3'd6;
    nx(3);
    ext_clk = 1;
    nx(5); expect_item(K_CNT, 9, "R4 rising ignored in select 6");
    ext_clk = 0;
    nx(2); expect_item(K_CNT, 9, "R4 fall not yet");
    nx(); expect_item(K_CNT, 10, "R4 fall tick on third edge");
    clk_sel = 3'd0;
    nx(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule